// File: doc/BRIEF.md
# Texture Coordinate Wrap and Tiled Texel Addressing

This block takes one normalized texture coordinate pair per request and produces the offset of the addressed texel inside a tiled texture image. Each fixed-point coordinate is multiplied by the texture dimension on its axis (width for s, height for t), and the product is truncated toward zero to a signed integer. A two-bit wrap code for each axis, read from a configuration word, then either clamps the integer to the texture edge or folds it back into the texture by a modulo. A wrap code the block does not support, or a zero texture size, yields a zero coordinate and raises an error flag.

The wrapped pair is turned into a linear texel index. The image is stored as 8x8 tiles laid out row-major, and the texels inside each tile follow a three-level quad (Z-order) interleave. The two axes are computed side by side in one combinational pass, and the results are registered. A request presented with `in_valid` returns its results, with `out_valid`, one clock later.

Top module: `texcoord_tiler`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `s_out`, `t_out`, `texel_idx` and `err_out` are all 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise; results appear one clock after the request.
- R3: The integer coordinate is (coordinate × size) / 2^FRAC_W truncated toward zero, with u and v read as signed fixed point (FRAC_W = 12 by default). For example, -409/4096 × 10 gives 0 and not -1.
- R4: Wrap code 0 (clamp) limits the integer to 0..size-1. Negative values become 0, and values at or above size become size-1.
- R5: Wrap code 2 (repeat) reads the signed 32-bit integer as unsigned and reduces it modulo size. For example, -1 with size 10 gives 4294967295 mod 10 = 5.
- R6: Wrap codes 1 and 3 give a coordinate of 0 on that axis and set `err_out`.
- R7: A size of 0 on an axis gives a coordinate of 0 on that axis and sets `err_out` in any wrap mode.
- R8: The s wrap code is `cfg_word[9:8]` and the t wrap code is `cfg_word[12:11]`. All other configuration bits have no effect on any output.
- R9: `texel_idx[5:0]` is the quad interleave of the low three bits of s and t. Bit 2k holds s bit k and bit 2k+1 holds t bit k, for k = 0, 1, 2.
- R10: `texel_idx` = ((t/8) × (width/8) + s/8) × 64 + the within-tile index, using integer division and taken modulo 2^32.
- R11: In a cycle with `in_valid` low, `s_out`, `t_out`, `texel_idx` and `err_out` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| u_in | input | COORD_W (24) | Signed fixed-point s coordinate, FRAC_W fraction bits |
| v_in | input | COORD_W (24) | Signed fixed-point t coordinate, FRAC_W fraction bits |
| tex_width | input | SIZE_W (16) | Texture width in texels |
| tex_height | input | SIZE_W (16) | Texture height in texels |
| cfg_word | input | CFG_W (32) | Configuration word holding both wrap codes |
| out_valid | output | 1 | Result strobe, one clock after the request |
| s_out | output | SIZE_W (16) | Wrapped s coordinate |
| t_out | output | SIZE_W (16) | Wrapped t coordinate |
| texel_idx | output | IDX_W (32) | Linear tiled texel index |
| err_out | output | 1 | Unsupported wrap code or zero size on either axis |

## Verification
Every result is registered exactly once, so any fault in the scaling, wrapping or address logic shows at the ports in the cycle right after the request. A faulty wrap mode shows as a coordinate at or above the texture size, or as a missing error flag. A mistake in the quad interleave breaks the fixed relation between the low six index bits and the low three bits of `s_out` and `t_out` in that same cycle. A faulty hold path shows as outputs that change during idle cycles.

// File: rtl/texwrap_pkg.sv
package texwrap_pkg;

  typedef enum logic [1:0] {
    WM_CLAMP  = 2'd0,
    WM_RSV1   = 2'd1,
    WM_REPEAT = 2'd2,
    WM_RSV3   = 2'd3
  } wrap_mode_e;

  // Bit positions of the per-axis wrap fields in the configuration word
  localparam int S_MODE_LSB = 8;
  localparam int T_MODE_LSB = 11;

  typedef struct packed {
    logic [31:0] val;
    logic        err;
  } wrap_res_t;

  // Arithmetic shift of a signed product, corrected so the quotient rounds toward zero
  function automatic logic [31:0] scale_trunc(input logic signed [63:0] prod, input int frac);
    logic signed [63:0] q;
    logic [63:0]        mask;
    mask = (64'd1 << frac) - 64'd1;
    q    = prod >>> frac;
    if (prod[63] && ((prod & mask) != 64'd0)) q = q + 64'sd1;
    return q[31:0];
  endfunction

  function automatic wrap_res_t wrap_coord(input wrap_mode_e mode, input logic [31:0] coord,
                                           input logic [31:0] size);
    wrap_res_t r;
    r.val = 32'd0;
    r.err = 1'b0;
    if (size == 32'd0) begin
      r.err = 1'b1;
    end else begin
      case (mode)
        WM_CLAMP: begin
          if (coord[31])         r.val = 32'd0;
          else if (coord >= size) r.val = size - 32'd1;
          else                    r.val = coord;
        end
        WM_REPEAT: r.val = coord % size;
        default:   r.err = 1'b1;
      endcase
    end
    return r;
  endfunction

  // Three quad levels: s bit k -> 2k, t bit k -> 2k+1
  function automatic logic [5:0] quad_interleave(input logic [2:0] s, input logic [2:0] t);
    logic [5:0] m;
    for (int k = 0; k < 3; k++) begin
      m[2*k]   = s[k];
      m[2*k+1] = t[k];
    end
    return m;
  endfunction

endpackage

// File: rtl/texcoord_scale.sv
module texcoord_scale #(
  parameter int COORD_W = 24,
  parameter int FRAC_W  = 12,
  parameter int SIZE_W  = 16
) (
  input  logic signed [COORD_W-1:0] coord,
  input  logic [SIZE_W-1:0]         size,
  output logic [31:0]               ival
);
  import texwrap_pkg::*;

  logic signed [63:0] coord_x;
  logic signed [63:0] size_x;
  logic signed [63:0] prod;

  always_comb begin
    coord_x = {{(64-COORD_W){coord[COORD_W-1]}}, coord};
    size_x  = {{(64-SIZE_W){1'b0}}, size};
    prod    = coord_x * size_x;
    ival    = scale_trunc(prod, FRAC_W);
  end
endmodule

// File: rtl/texcoord_wrap.sv
module texcoord_wrap #(
  parameter int SIZE_W = 16
) (
  input  logic [1:0]        mode,
  input  logic [31:0]       ival,
  input  logic [SIZE_W-1:0] size,
  output logic [SIZE_W-1:0] wrapped,
  output logic              err
);
  import texwrap_pkg::*;

  wrap_res_t res;

  always_comb begin
    res     = wrap_coord(wrap_mode_e'(mode), ival, {{(32-SIZE_W){1'b0}}, size});
    wrapped = res.val[SIZE_W-1:0];
    err     = res.err;
  end
endmodule

// File: rtl/tile_addr.sv
module tile_addr #(
  parameter int SIZE_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic [SIZE_W-1:0] s,
  input  logic [SIZE_W-1:0] t,
  input  logic [SIZE_W-1:0] width,
  output logic [IDX_W-1:0]  idx
);
  import texwrap_pkg::*;

  localparam int TILE_SH = 3;
  localparam int TEXELS_SH = 2 * TILE_SH;

  logic [IDX_W-1:0] tiles_per_row;
  logic [IDX_W-1:0] tile_row;
  logic [IDX_W-1:0] tile_col;
  logic [IDX_W-1:0] tile_num;
  logic [5:0]       in_tile;

  always_comb begin
    tiles_per_row = IDX_W'(width >> TILE_SH);
    tile_row      = IDX_W'(t >> TILE_SH);
    tile_col      = IDX_W'(s >> TILE_SH);
    tile_num      = tile_row * tiles_per_row + tile_col;
    in_tile       = quad_interleave(s[2:0], t[2:0]);
    idx           = (tile_num << TEXELS_SH) | IDX_W'(in_tile);
  end
endmodule

// File: rtl/texcoord_tiler.sv
module texcoord_tiler #(
  parameter int COORD_W = 24,
  parameter int FRAC_W  = 12,
  parameter int SIZE_W  = 16,
  parameter int CFG_W   = 32,
  parameter int IDX_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [COORD_W-1:0] u_in,
  input  logic signed [COORD_W-1:0] v_in,
  input  logic [SIZE_W-1:0]         tex_width,
  input  logic [SIZE_W-1:0]         tex_height,
  input  logic [CFG_W-1:0]          cfg_word,
  output logic                      out_valid,
  output logic [SIZE_W-1:0]         s_out,
  output logic [SIZE_W-1:0]         t_out,
  output logic [IDX_W-1:0]          texel_idx,
  output logic                      err_out
);
  import texwrap_pkg::*;

  localparam int NAXES = 2;

  logic signed [COORD_W-1:0] axis_coord [NAXES];
  logic [SIZE_W-1:0]         axis_size  [NAXES];
  logic [1:0]                axis_mode  [NAXES];
  logic [31:0]               axis_int   [NAXES];
  logic [SIZE_W-1:0]         axis_wrap  [NAXES];
  logic [NAXES-1:0]          wrap_err;
  logic [IDX_W-1:0]          idx_next;

  always_comb begin
    axis_coord[0] = u_in;
    axis_coord[1] = v_in;
    axis_size[0]  = tex_width;
    axis_size[1]  = tex_height;
    axis_mode[0]  = cfg_word[S_MODE_LSB +: 2];
    axis_mode[1]  = cfg_word[T_MODE_LSB +: 2];
  end

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    texcoord_scale #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .SIZE_W(SIZE_W)) scale_i (
      .coord(axis_coord[a]),
      .size (axis_size[a]),
      .ival (axis_int[a])
    );
    texcoord_wrap #(.SIZE_W(SIZE_W)) wrap_i (
      .mode   (axis_mode[a]),
      .ival   (axis_int[a]),
      .size   (axis_size[a]),
      .wrapped(axis_wrap[a]),
      .err    (wrap_err[a])
    );
  end

  tile_addr #(.SIZE_W(SIZE_W), .IDX_W(IDX_W)) addr_i (
    .s    (axis_wrap[0]),
    .t    (axis_wrap[1]),
    .width(tex_width),
    .idx  (idx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      s_out     <= '0;
      t_out     <= '0;
      texel_idx <= '0;
      err_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        s_out     <= axis_wrap[0];
        t_out     <= axis_wrap[1];
        texel_idx <= idx_next;
        err_out   <= |wrap_err;
      end
    end
  end
endmodule

// File: rtl/texcoord_tiler_chk.sv
module texcoord_tiler_chk #(
  parameter int SIZE_W = 16,
  parameter int CFG_W  = 32,
  parameter int IDX_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SIZE_W-1:0] tex_width,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              out_valid,
  input logic [SIZE_W-1:0] s_out,
  input logic [SIZE_W-1:0] t_out,
  input logic [IDX_W-1:0]  texel_idx,
  input logic              err_out,
  input logic [1:0]        wrap_err
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_word[9:8] == 2'd0 && tex_width != '0) |=> (s_out < $past(tex_width)));

  a_r5_repeat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_word[9:8] == 2'd2 && tex_width != '0) |=> (s_out < $past(tex_width)));

  a_r6_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_word[8]) |=> (err_out && s_out == '0));

  a_r6_axis_err_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wrap_err != 2'b00) |=> err_out);

  a_r7_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tex_width == '0) |=> (err_out && s_out == '0));

  a_r9_quad_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (texel_idx[0] == s_out[0] && texel_idx[1] == t_out[0] &&
                   texel_idx[2] == s_out[1] && texel_idx[3] == t_out[1] &&
                   texel_idx[4] == s_out[2] && texel_idx[5] == t_out[2]));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(s_out) && $stable(t_out) && $stable(texel_idx) && $stable(err_out)));

endmodule

bind texcoord_tiler texcoord_tiler_chk #(.SIZE_W(SIZE_W), .CFG_W(CFG_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/texcoord_tiler_tb_top.sv
module texcoord_tiler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC = 12;
  localparam int NV = 11;

  // Stimulus table: u, v, width, height, s code, t code
  localparam int TU [NV] = '{2048,  768, -256, 4096, -410, -409, 1000, 1000, 3000, 4095, 40000};
  localparam int TV [NV] = '{1024, 1280, 5000, -4096, 100,  300, 1000, 1000, 2000, 4095, -30000};
  localparam int TW [NV] = '{  64,   16,   16,   16,   10,   10,   20,   20,    0,  256,   100};
  localparam int TH [NV] = '{  32,   16,   16,   16,   10,   24,   12,   12,    8,  128,    50};
  localparam int TS [NV] = '{   2,    0,    2,    0,    2,    2,    1,    0,    0,    0,     2};
  localparam int TT [NV] = '{   2,    0,    2,    0,    0,    2,    0,    3,    0,    2,     0};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [23:0] u_in = '0;
  logic signed [23:0] v_in = '0;
  logic [15:0]        tex_width = '0;
  logic [15:0]        tex_height = '0;
  logic [31:0]        cfg_word = '0;
  logic               out_valid;
  logic [15:0]        s_out;
  logic [15:0]        t_out;
  logic [31:0]        texel_idx;
  logic               err_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  texcoord_tiler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .u_in(u_in), .v_in(v_in),
    .tex_width(tex_width), .tex_height(tex_height), .cfg_word(cfg_word),
    .out_valid(out_valid), .s_out(s_out), .t_out(t_out), .texel_idx(texel_idx),
    .err_out(err_out)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Model of one axis: returns coordinate, sets err
  function automatic longint model_axis(input int c, input int size, input int code, output bit err);
    longint i;
    longint r;
    i = (longint'(c) * longint'(size)) / (longint'(1) << FRAC);
    err = 1'b0;
    r = 0;
    if (size == 0 || code == 1 || code == 3) err = 1'b1;
    else if (code == 0) r = (i < 0) ? 0 : ((i >= size) ? size - 1 : i);
    else r = (i & 64'hFFFF_FFFF) % size;
    return r;
  endfunction

  function automatic longint model_idx(input longint s, input longint t, input int w);
    longint inner = 0;
    longint tile;
    for (int k = 0; k < 3; k++) begin
      inner += ((s >> k) & 1) * (longint'(1) << (2*k));
      inner += ((t >> k) & 1) * (longint'(1) << (2*k+1));
    end
    tile = (t / 8) * (w / 8) + (s / 8);
    return (tile * 64 + inner) & 64'hFFFF_FFFF;
  endfunction

  function automatic string mode_tag(input int size, input int code);
    if (size == 0) return "R7";
    if (code == 0) return "R4";
    if (code == 2) return "R5";
    return "R6";
  endfunction

  task automatic apply(input int u, input int v, input int w, input int h, input logic [31:0] cfg);
    @(negedge clk);
    in_valid   = 1'b1;
    u_in       = 24'(u);
    v_in       = 24'(v);
    tex_width  = 16'(w);
    tex_height = 16'(h);
    cfg_word   = cfg;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_cfg(input int cs, input int ct);
    return (32'(cs) << 8) | (32'(ct) << 11);
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "s_out", s_out, 0);
    check("R1", "texel_idx", texel_idx, 0);
    check("R1", "err_out", err_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      bit es, et;
      longint s_e, t_e;
      s_e = model_axis(TU[i], TW[i], TS[i], es);
      t_e = model_axis(TV[i], TH[i], TT[i], et);
      apply(TU[i], TV[i], TW[i], TH[i], mk_cfg(TS[i], TT[i]));
      check("R2", "out_valid", out_valid, 1);
      check(mode_tag(TW[i], TS[i]), $sformatf("s_out vec %0d", i), s_out, s_e);
      check(mode_tag(TH[i], TT[i]), $sformatf("t_out vec %0d", i), t_out, t_e);
      check("R10", $sformatf("texel_idx vec %0d", i), texel_idx, model_idx(s_e, t_e, TW[i]));
      check((es || et) ? "R6" : "R3", $sformatf("err_out vec %0d", i), err_out, (es || et) ? 1 : 0);
    end

    // R2: valid drops one cycle after idle
    @(negedge clk);
    check("R2", "out_valid idle", out_valid, 0);

    // R9: s=3, t=5 inside tile 0 -> 39
    apply(768, 1280, 16, 16, mk_cfg(0, 0));
    check("R9", "quad index", texel_idx, 39);
    // R10: s=11, t=13, width 16 -> tile 3 -> 231
    apply(2816, 3328, 16, 16, mk_cfg(0, 0));
    check("R10", "tiled index", texel_idx, 231);

    // R5: -1 repeat with size 10 -> 5
    apply(-410, 0, 10, 10, mk_cfg(2, 2));
    check("R5", "unsigned modulo", s_out, 5);
    // R3: -0.998 truncates to 0, so repeat gives 0
    apply(-409, 0, 10, 10, mk_cfg(2, 2));
    check("R3", "truncate toward zero", s_out, 0);
    // R4: clamp at high edge
    apply(4096, -4096, 16, 16, mk_cfg(0, 0));
    check("R4", "clamp high", s_out, 15);
    check("R4", "clamp low", t_out, 0);

    // R8: other config bits set are ignored; codes repeat/repeat
    apply(-256, 5000, 16, 16, ~32'h0000_1B00 | mk_cfg(2, 2));
    check("R8", "s with junk bits", s_out, 15);
    check("R8", "t with junk bits", t_out, 3);
    check("R8", "err with junk bits", err_out, 0);
    // R8: t field alone bad -> err, s still fine
    apply(768, 1280, 16, 16, mk_cfg(0, 1));
    check("R8", "t field position err", err_out, 1);
    check("R8", "s untouched by t code", s_out, 3);

    // R11: hold while idle
    apply(2816, 3328, 16, 16, mk_cfg(0, 0));
    @(negedge clk);
    u_in = 24'sd100; v_in = 24'sd7; tex_width = 16'd3; cfg_word = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    check("R11", "s hold", s_out, 11);
    check("R11", "t hold", t_out, 13);
    check("R11", "idx hold", texel_idx, 231);
    check("R11", "err hold", err_out, 0);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "s after reset", s_out, 0);
    check("R1", "idx after reset", texel_idx, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule